// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller

This block connects a synchronous request port to an asynchronous DRAM with a 16-bit word, 8 shared address pins and one column strobe per byte lane. Each request carries a word address, a read/write flag, write data and a byte-enable mask. The request is accepted with a valid/ready handshake. The controller splits the address into a row phase and a column phase, strobes them onto the shared pins, and returns read data through a one-cycle response pulse.

Once a row is open it stays open. A later request to the same row costs only a column strobe. A request to another row closes the open row, waits out the precharge time and then opens the new row. All writes are early writes: the write strobe and the data are set up before any column strobe falls, so the memory never drives the bus during a write. A byte write strobes only the selected lanes.

Refresh is arbitrated through a request/grant pair. On a refresh request the controller closes the row at the next access boundary, raises the grant, and holds both strobes idle until the request is withdrawn. Every gap is an integer count of clock cycles set by a parameter. A guard counter closes any row before its strobe-low time reaches the allowed maximum.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the row strobe, both column strobes, the write strobe and the output-enable strobe are high, the data-bus enable is low and the refresh grant is low.
- R2: Request address bits 15:8 appear on the address pins as the row when the row strobe falls. Bits 7:0 appear there as the column when a column strobe falls.
- R3: A write with byte-enable bit 0 set strobes the lower lane and stores data bits 7:0. Bit 1 strobes the upper lane and stores bits 15:8. With both set the whole word is stored. A lane that is not enabled keeps its old contents.
- R4: For every write, the write strobe is low and the data bus is driven at least one cycle before the column strobe falls, and both stay that way while the strobe is low. The output-enable strobe is never low together with the write strobe.
- R5: A request to the row that is already open produces no new row-strobe falling edge.
- R6: Before a row is reopened, the row strobe stays high for at least RP_CYC cycles. The row strobe is low for at least RCD_CYC cycles before a column strobe falls. A column strobe is only ever low while the row strobe is low.
- R7: A read returns the stored word, with lanes not enabled reading as zero. The response is a single-cycle pulse.
- R8: The refresh grant is raised only while the row strobe and both column strobes are high and the request port is not ready. The grant holds until the refresh request is dropped. Accesses resume correctly afterwards.
- R9: The row strobe never stays low for more than RAS_MAX_CYC consecutive cycles. The open row is closed early when needed, even during back-to-back page hits.
- R10: Each column strobe stays low for at least CAS_CYC cycles. Within one open row it stays high for at least CP_CYC cycles between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address: row in 15:8, column in 7:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lanes: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| ref_req | input | 1 | Refresh logic asks for the bus |
| ref_gnt | output | 1 | Bus handed to refresh logic |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per lane, bit 0 lower byte |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data toward the memory |
| dram_dq_oe | output | 1 | Enable for the data pad drivers |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
The assertions assume that the refresh logic holds its request until it has seen the grant and then drops it. They also assume that every timing parameter is at least one cycle and that the strobe-low cap leaves room for one full access. The bench drives the refresh request only while no grant is outstanding, and it releases the request after a few granted cycles. It runs the controller with short legal gaps and a small strobe-low cap, so that the guard and the page closures actually occur. A cycle-level memory model in the bench records edge-to-edge gaps, strobe ordering and the data stored in each lane.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,   // no row open, precharge satisfied
      ST_PRE,    // row strobe high, counting precharge
      ST_RSET,   // row address on pins, strobe still high
      ST_RCD,    // row strobe low, waiting before column
      ST_CSET,   // column address, write strobe and data set up
      ST_COL,    // column strobe low
      ST_CP,     // column strobe high, column held
      ST_OPEN,   // row open, waiting for the next request
      ST_REF     // bus granted to refresh logic
   } fpm_state_e;

   function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                           int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/dram_gap_timer.sv
module dram_gap_timer #(
   parameter int CW = 2,
   parameter logic [CW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= RST_VAL;
      else if (load)       cnt_q <= load_val;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // a gap is only restarted after the previous one ran out
   assert_no_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> zero);
endmodule

// File: rtl/dram_ras_watch.sv
module dram_ras_watch #(
   parameter int LIMIT  = 10000,
   parameter int MARGIN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_low,
   output logic near_cap
);
   localparam int WW = $clog2(LIMIT + 1);
   localparam logic [WW-1:0] LIM_V = WW'(LIMIT);
   localparam logic [WW-1:0] THR_V = WW'(LIMIT - MARGIN);

   logic [WW-1:0] low_q;  // completed low cycles before this one

   always_ff @(posedge clk) begin
      if (!rst_n || !ras_low) low_q <= '0;
      else if (low_q != LIM_V) low_q <= low_q + 1'b1;
   end

   assign near_cap = (low_q > THR_V);

   assert_ras_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ras_low |-> (low_q < LIM_V));
endmodule

// File: rtl/dram_page_tag.sv
module dram_page_tag #(
   parameter int RW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          open_evt,
   input  logic          close_evt,
   input  logic [RW-1:0] row_in,
   input  logic [RW-1:0] probe_row,
   output logic          hit
);
   logic          vld_q;
   logic [RW-1:0] row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         row_q <= '0;
      end else if (close_evt) begin
         vld_q <= 1'b0;
      end else if (open_evt) begin
         vld_q <= 1'b1;
         row_q <= row_in;
      end
   end

   assign hit = vld_q && (row_q == probe_row);

   // a row is only opened after the previous one was closed
   assert_single_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
      open_evt |-> !vld_q);
   assert_evt_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(open_evt && close_evt));
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
   import fpm_dram_pkg::*;
#(
   parameter int ROW_W       = 8,
   parameter int COL_W       = 8,
   parameter int DATA_W      = 16,
   parameter int RP_CYC      = 3,
   parameter int RCD_CYC     = 2,
   parameter int CAS_CYC     = 2,
   parameter int CP_CYC      = 1,
   parameter int RAS_MAX_CYC = 10000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [ROW_W+COL_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic [DATA_W/8-1:0]      req_be,
   output logic                     rsp_valid,
   output logic [DATA_W-1:0]        rsp_rdata,
   input  logic                     ref_req,
   output logic                     ref_gnt,
   output logic                     dram_ras_n,
   output logic [DATA_W/8-1:0]      dram_cas_n,
   output logic                     dram_we_n,
   output logic                     dram_oe_n,
   output logic [ROW_W-1:0]         dram_addr,
   output logic [DATA_W-1:0]        dram_dq_out,
   output logic                     dram_dq_oe,
   input  logic [DATA_W-1:0]        dram_dq_in
);
   localparam int LANES  = DATA_W / 8;
   localparam int TMAX   = int'(max_of4(RP_CYC, RCD_CYC, CAS_CYC, CP_CYC));
   localparam int CW     = $clog2(TMAX + 1);
   localparam int MARGIN = CAS_CYC + CP_CYC + 3;
   localparam logic [CW-1:0] LD_RP  = CW'(RP_CYC - 1);
   localparam logic [CW-1:0] LD_RCD = CW'(RCD_CYC - 1);
   localparam logic [CW-1:0] LD_CAS = CW'(CAS_CYC - 1);
   localparam logic [CW-1:0] LD_CP  = CW'(CP_CYC - 1);

   // elaboration-time parameter checks
   if (ROW_W != COL_W) begin : g_bad_pins
      $error("row and column widths must match the shared pins");
   end
   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("data width must be whole bytes");
   end
   if (RP_CYC < 1 || RCD_CYC < 1 || CAS_CYC < 1 || CP_CYC < 1) begin : g_bad_gap
      $error("every gap must be at least one cycle");
   end
   if (RAS_MAX_CYC < RCD_CYC + CAS_CYC + CP_CYC + 4 || RAS_MAX_CYC <= MARGIN) begin : g_bad_cap
      $error("row strobe cap too short for one access");
   end

   fpm_state_e st_q, st_nx;
   logic             pend_q;
   logic             cur_we_q;
   logic [ROW_W-1:0] cur_row_q;
   logic [COL_W-1:0] cur_col_q;
   logic [DATA_W-1:0] cur_wd_q;
   logic [LANES-1:0] cur_be_q;
   logic             rsp_v_q;
   logic [DATA_W-1:0] rsp_d_q;

   logic          tmr_load, tmr_zero, near_cap, row_hit, accept;
   logic [CW-1:0] tmr_val;
   logic [DATA_W-1:0] lane_mask;
   logic          ras_low, cas_act;

   dram_gap_timer #(.CW(CW), .RST_VAL(LD_RP)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

   dram_ras_watch #(.LIMIT(RAS_MAX_CYC), .MARGIN(MARGIN)) u_watch (
      .clk(clk), .rst_n(rst_n), .ras_low(ras_low), .near_cap(near_cap));

   dram_page_tag #(.RW(ROW_W)) u_tag (
      .clk(clk), .rst_n(rst_n),
      .open_evt(st_q == ST_RSET),
      .close_evt(st_nx == ST_PRE && st_q != ST_PRE),
      .row_in(cur_row_q),
      .probe_row(req_addr[ROW_W+COL_W-1:COL_W]),
      .hit(row_hit));

   assign req_ready = !ref_req &&
                      ((st_q == ST_IDLE) || (st_q == ST_OPEN && !near_cap));
   assign accept    = req_valid && req_ready;

   always_comb begin
      st_nx    = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st_q)
         ST_IDLE: if (ref_req) st_nx = ST_REF;
                  else if (req_valid) st_nx = ST_RSET;
         ST_REF:  if (!ref_req) begin
                     st_nx = ST_PRE; tmr_load = 1'b1; tmr_val = LD_RP;
                  end
         ST_PRE:  if (tmr_zero) st_nx = pend_q ? ST_RSET : ST_IDLE;
         ST_RSET: begin st_nx = ST_RCD; tmr_load = 1'b1; tmr_val = LD_RCD; end
         ST_RCD:  if (tmr_zero) st_nx = ST_CSET;
         ST_CSET: begin st_nx = ST_COL; tmr_load = 1'b1; tmr_val = LD_CAS; end
         ST_COL:  if (tmr_zero) begin
                     st_nx = ST_CP; tmr_load = 1'b1; tmr_val = LD_CP;
                  end
         ST_CP:   if (tmr_zero) st_nx = ST_OPEN;
         ST_OPEN: if (ref_req || near_cap || (req_valid && !row_hit)) begin
                     st_nx = ST_PRE; tmr_load = 1'b1; tmr_val = LD_RP;
                  end else if (req_valid) begin
                     st_nx = ST_CSET;
                  end
         default: st_nx = ST_PRE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_PRE;
         pend_q    <= 1'b0;
         cur_we_q  <= 1'b0;
         cur_row_q <= '0;
         cur_col_q <= '0;
         cur_wd_q  <= '0;
         cur_be_q  <= '0;
         rsp_v_q   <= 1'b0;
         rsp_d_q   <= '0;
      end else begin
         st_q <= st_nx;
         if (accept) begin
            cur_we_q  <= req_write;
            cur_row_q <= req_addr[ROW_W+COL_W-1:COL_W];
            cur_col_q <= req_addr[COL_W-1:0];
            cur_wd_q  <= req_wdata;
            cur_be_q  <= req_be;
         end
         if (accept && st_q == ST_OPEN && !row_hit) pend_q <= 1'b1;
         else if (st_q == ST_RSET)                 pend_q <= 1'b0;
         rsp_v_q <= (st_q == ST_COL) && tmr_zero && !cur_we_q;
         if ((st_q == ST_COL) && tmr_zero && !cur_we_q)
            rsp_d_q <= dram_dq_in & lane_mask;
      end
   end

   // one column strobe and one read mask slice per byte lane
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign dram_cas_n[i]        = !((st_q == ST_COL) && cur_be_q[i]);
      assign lane_mask[i*8 +: 8]  = {8{cur_be_q[i]}};
   end

   assign ras_low     = (st_q == ST_RCD) || (st_q == ST_CSET) || (st_q == ST_COL) ||
                        (st_q == ST_CP)  || (st_q == ST_OPEN);
   assign dram_ras_n  = !ras_low;
   assign dram_dq_oe  = cur_we_q && ((st_q == ST_CSET) || (st_q == ST_COL));
   assign dram_we_n   = !dram_dq_oe;
   assign dram_oe_n   = !(!cur_we_q && st_q == ST_COL);
   assign dram_addr   = ((st_q == ST_CSET) || (st_q == ST_COL) || (st_q == ST_CP)) ?
                        cur_col_q : cur_row_q;
   assign dram_dq_out = cur_wd_q;
   assign ref_gnt     = (st_q == ST_REF);
   assign rsp_valid   = rsp_v_q;
   assign rsp_rdata   = rsp_d_q;
   assign cas_act     = !(&dram_cas_n);

   assert_cas_in_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cas_act |-> !dram_ras_n);
   assert_early_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cas_act) && !dram_we_n) |-> $past(!dram_we_n));
   assert_wdata_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_act && !dram_we_n) |-> dram_dq_oe);
   assert_oe_we_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_oe_n |-> dram_we_n);
   assert_gnt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ref_gnt |-> (dram_ras_n && !cas_act && !req_ready));
   assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

// File: tb/fpm_dram_ctrl_tb.sv
module fpm_dram_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int T_RP = 3, T_RCD = 2, T_CAS = 2, T_CP = 1, T_RASMAX = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic req_ready, rsp_valid, ref_gnt;
   logic [15:0] rsp_rdata, dram_dq_out;
   logic [15:0] dram_dq_in = '0;
   logic dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [1:0] dram_cas_n;
   logic [7:0] dram_addr;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpm_dram_ctrl #(.RP_CYC(T_RP), .RCD_CYC(T_RCD), .CAS_CYC(T_CAS), .CP_CYC(T_CP),
                   .RAS_MAX_CYC(T_RASMAX)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_gnt(ref_gnt),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
      .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

   // ---------------- cycle-level memory model ----------------
   logic [15:0] mem [int];
   logic [7:0]  m_row = '0, m_col = '0;
   int ras_falls = 0, hi_run = 0, lo_run = 0, max_lo = 0, min_rp = 999;
   int since_ras = 0, min_rcd = 999, cas_lo_run = 0, min_cas = 999;
   int cas_hi_run = 0, min_cp = 999, early_viol = 0, drive_viol = 0;
   bit seen_fall = 1'b0, cas_hi_valid = 1'b0;
   logic prev_ras = 1'b1, prev_ca = 1'b0, prev_we = 1'b1;

   always @(posedge clk) begin
      logic ca;
      logic [15:0] w;
      int k;
      ca = !(&dram_cas_n);
      if (rst_n) begin
         if (dram_ras_n) begin
            hi_run++; lo_run = 0;
         end else begin
            if (prev_ras) begin
               if (seen_fall && hi_run < min_rp) min_rp = hi_run;
               seen_fall = 1'b1; ras_falls++; m_row = dram_addr;
               since_ras = 0; cas_hi_valid = 1'b0;
            end
            hi_run = 0; lo_run++;
            if (lo_run > max_lo) max_lo = lo_run;
         end
         if (ca) begin
            if (!prev_ca) begin
               if (since_ras < min_rcd) min_rcd = since_ras;
               if (cas_hi_valid && cas_hi_run < min_cp) min_cp = cas_hi_run;
               m_col = dram_addr;
               if (!dram_we_n) begin
                  if (prev_we) early_viol++;
                  if (!dram_dq_oe) drive_viol++;
                  k = {16'h0, m_row, dram_addr};
                  w = mem.exists(k) ? mem[k] : 16'h0;
                  if (!dram_cas_n[0]) w[7:0]  = dram_dq_out[7:0];
                  if (!dram_cas_n[1]) w[15:8] = dram_dq_out[15:8];
                  mem[k] = w;
               end
               cas_lo_run = 0;
            end
            cas_lo_run++;
         end else begin
            if (prev_ca) begin
               if (cas_lo_run < min_cas) min_cas = cas_lo_run;
               cas_hi_run = 0; cas_hi_valid = !dram_ras_n;
            end
            cas_hi_run++;
         end
         if (!dram_ras_n) since_ras++;
         prev_ras = dram_ras_n; prev_ca = ca; prev_we = dram_we_n;
      end
   end

   always @(negedge clk) begin
      logic [15:0] w;
      int k;
      k = {16'h0, m_row, dram_addr};
      w = mem.exists(k) ? mem[k] : 16'h0;
      if (dram_oe_n) w = '0;
      if (dram_cas_n[0]) w[7:0]  = '0;
      if (dram_cas_n[1]) w[15:8] = '0;
      dram_dq_in <= w;
   end

   // ---------------- helpers ----------------
   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] be);
      int n = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      while (!req_ready && n < 200) begin @(negedge clk); n++; end
      if (n >= 200) chk(1'b0, "R8 request never accepted", 0, 1);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
      int n = 0;
      issue(1'b1, a, d, be);
      while (!req_ready && n < 200) begin @(negedge clk); n++; end
   endtask

   task automatic do_read(input logic [15:0] a, input logic [1:0] be, output logic [15:0] q);
      int n = 0;
      issue(1'b0, a, 16'h0, be);
      while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
      q = rsp_rdata;
      chk(rsp_valid == 1'b1, "R7 read response arrives", int'(rsp_valid), 1);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R7 response is one cycle", int'(rsp_valid), 0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(dram_ras_n && (&dram_cas_n) && dram_we_n && dram_oe_n && !dram_dq_oe && !ref_gnt,
          "R1 strobes idle in reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 5'h1f);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dram_ras_n && (&dram_cas_n) && !dram_dq_oe && !ref_gnt,
          "R1 strobes idle after reset", {dram_ras_n, dram_cas_n, dram_dq_oe}, 4'he);
   endtask

   task automatic t_word();
      logic [15:0] q;
      do_write(16'hABCD, 16'h1234, 2'b11);
      chk(m_row == 8'hAB, "R2 row on pins", int'(m_row), 'hAB);
      chk(m_col == 8'hCD, "R2 column on pins", int'(m_col), 'hCD);
      do_read(16'hABCD, 2'b11, q);
      chk(q == 16'h1234, "R7 full word read", int'(q), 'h1234);
   endtask

   task automatic t_bytes();
      logic [15:0] q;
      do_write(16'h3344, 16'hFFFF, 2'b11);
      do_write(16'h3344, 16'h00A5, 2'b01);
      do_read(16'h3344, 2'b11, q);
      chk(q == 16'hFFA5, "R3 lower lane only", int'(q), 'hFFA5);
      do_write(16'h3344, 16'h5A00, 2'b10);
      do_read(16'h3344, 2'b11, q);
      chk(q == 16'h5AA5, "R3 upper lane only", int'(q), 'h5AA5);
   endtask

   task automatic t_page_hit();
      logic [15:0] q;
      int f;
      do_write(16'h7700, 16'h0F0F, 2'b11);
      f = ras_falls;
      do_read(16'h7700, 2'b11, q);
      chk(q == 16'h0F0F, "R5 hit read data", int'(q), 'h0F0F);
      do_write(16'h7701, 16'hCAFE, 2'b11);
      do_read(16'h7701, 2'b11, q);
      chk(q == 16'hCAFE, "R5 hit write data", int'(q), 'hCAFE);
      chk(ras_falls == f, "R5 no new row cycle on hit", ras_falls, f);
   endtask

   task automatic t_page_miss();
      logic [15:0] q;
      int f;
      f = ras_falls;
      do_write(16'h8800, 16'h2468, 2'b11);
      chk(ras_falls == f + 1, "R6 miss opens one new row", ras_falls, f + 1);
      do_read(16'h7701, 2'b11, q);
      chk(q == 16'hCAFE, "R6 old row data after reopen", int'(q), 'hCAFE);
   endtask

   task automatic t_byte_read();
      logic [15:0] q;
      do_write(16'h9900, 16'hBEEF, 2'b11);
      do_read(16'h9900, 2'b01, q);
      chk(q == 16'h00EF, "R7 lower-lane read", int'(q), 'h00EF);
      do_read(16'h9900, 2'b10, q);
      chk(q == 16'hBE00, "R7 upper-lane read", int'(q), 'hBE00);
   endtask

   task automatic t_refresh();
      logic [15:0] q;
      int n = 0, bad = 0;
      do_write(16'h4400, 16'h1111, 2'b11);
      @(negedge clk);
      ref_req = 1'b1;
      while (!ref_gnt && n < 100) begin @(negedge clk); n++; end
      chk(ref_gnt == 1'b1, "R8 grant raised", int'(ref_gnt), 1);
      for (int i = 0; i < 6; i++) begin
         if (!ref_gnt || !dram_ras_n || !(&dram_cas_n) || req_ready) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R8 bus quiet while granted", bad, 0);
      ref_req = 1'b0;
      @(negedge clk);
      chk(ref_gnt == 1'b0, "R8 grant dropped", int'(ref_gnt), 0);
      do_read(16'h4400, 2'b11, q);
      chk(q == 16'h1111, "R8 access after refresh", int'(q), 'h1111);
   endtask

   task automatic t_ras_cap();
      logic [15:0] q;
      int f, bad = 0;
      do_write(16'h5500, 16'h7777, 2'b11);
      f = ras_falls;
      for (int i = 0; i < 12; i++) begin
         do_read(16'h5500, 2'b11, q);
         if (q != 16'h7777) bad++;
      end
      chk(bad == 0, "R9 data across forced closes", bad, 0);
      chk(ras_falls > f, "R9 row closed by cap", ras_falls, f + 1);
      chk(max_lo <= T_RASMAX, "R9 longest row strobe low", max_lo, T_RASMAX);
   endtask

   task automatic t_timing();
      chk(min_rp >= T_RP, "R6 precharge gap", min_rp, T_RP);
      chk(min_rcd >= T_RCD, "R6 row to column gap", min_rcd, T_RCD);
      chk(min_cas >= T_CAS, "R10 column strobe width", min_cas, T_CAS);
      chk(min_cp >= T_CP && min_cp != 999, "R10 column precharge width", min_cp, T_CP);
      chk(early_viol == 0, "R4 write strobe before column", early_viol, 0);
      chk(drive_viol == 0, "R4 data driven on write", drive_viol, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      finish_run();
   end

   initial begin
      t_reset();
      t_word();
      t_bytes();
      t_page_hit();
      t_page_miss();
      t_byte_read();
      t_refresh();
      t_ras_cap();
      t_timing();
      finish_run();
   end
endmodule